// File: doc/BRIEF.md
# I2C Byte Queues with Trigger Interrupts

This block sits between a host register interface and an I2C bus engine and holds two byte queues: a transmit queue that the host fills and the engine drains, and a receive queue that the engine fills and the host drains. Each queue has its own enable and its own trigger level. The host uses the trigger interrupts to move data in bursts instead of byte by byte.

A transmit interrupt asks for more data while the transmit queue is low. A receive interrupt asks for a drain while the receive queue is high. A third source, the trailing interrupt, covers the end of a read. It fires when a few received bytes stay below the receive trigger and the engine delivers nothing new for a programmed number of idle periods. Writes to a full queue and reads from an empty queue are dropped. Each such event is latched in a sticky flag that the host clears by writing a 1. A packed status word reports the fill level and the full and empty flags of both queues. A per-source enable mask gates the sources into a single registered interrupt line.

Top module: `i2c_byte_queues`

## Requirements
- R1: Bytes accepted from `tx_wr` leave on `eng_tx_data` in arrival order. The byte appears in the cycle after the `eng_tx_pop` that takes it.
- R2: Bytes accepted from `eng_rx_push` leave on `rx_rdata` in arrival order. The byte appears in the cycle after the `rx_rd` that takes it.
- R3: `fifo_stat` holds the transmit level in [6:0], transmit full in bit 7 and transmit empty in bit 8. It holds the receive level in [22:16], receive full in bit 23 and receive empty in bit 24. All other bits are 0.
- R4: A `tx_wr` while the transmit queue is full is dropped and sets sticky bit 3 (transmit overrun). An `eng_tx_pop` while it is empty returns nothing and sets sticky bit 2 (transmit underrun). The queue state before the edge decides both.
- R5: An `eng_rx_push` while the receive queue is full is dropped and sets sticky bit 5 (receive overrun). An `rx_rd` while it is empty returns nothing and sets sticky bit 4 (receive underrun).
- R6: `irq_stat` bit 0 (transmit almost-empty) is 1 exactly while the transmit queue is enabled and its level is at or below `tx_trig`. The bit is level-driven, so clearing it has no effect.
- R7: `irq_stat` bit 1 (receive almost-full) is 1 exactly while the receive queue is enabled, not empty, and at or above `rx_trig`.
- R8: An idle counter runs while the receive queue is enabled and holds between 1 and `rx_trig`-1 bytes. An accepted push, or leaving that window, resets it. Each `idle_tick` advances it up to `trail_lim`. A tick that arrives while the counter already equals `trail_lim` sets sticky bit 6 (trailing), so the flag sets on the (`trail_lim`+1)-th idle tick.
- R9: Sticky bits 2 to 6 rise in the cycle after their event. They stay set until a cycle in which the matching `irq_clr` bit is 1. A new event in that same cycle wins over the clear.
- R10: `irq` is a register that takes the OR of `irq_stat & irq_en` from the previous cycle.
- R11: While a queue's enable is 0, it is emptied and holds no data. Writes, reads, pushes and pops on it are ignored and set no flag.
- R12: The depth is a parameter, 16 or 64 entries. The trigger inputs and level fields are wide enough to express a full queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit queue enable |
| rx_en | input | 1 | Receive queue enable |
| tx_trig | input | LVL_W | Transmit almost-empty trigger level |
| rx_trig | input | LVL_W | Receive almost-full trigger level |
| trail_lim | input | 4 | Idle periods before the trailing flag |
| idle_tick | input | 1 | One pulse per bus idle period |
| tx_wr | input | 1 | Host writes a byte to the transmit queue |
| tx_wdata | input | 8 | Host write byte |
| rx_rd | input | 1 | Host reads a byte from the receive queue |
| rx_rdata | output | 8 | Host read byte, valid the cycle after `rx_rd` |
| eng_tx_pop | input | 1 | Engine takes a byte from the transmit queue |
| eng_tx_data | output | 8 | Transmit byte, valid the cycle after `eng_tx_pop` |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| irq_en | input | 7 | Per-source interrupt enables |
| irq_clr | input | 7 | Write-1-to-clear strobes for sticky bits |
| irq_stat | output | 7 | Interrupt source status |
| fifo_stat | output | 32 | Queue level, full and empty word |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block at a depth of 16. At that depth both queues reach full within a few cycles. Overrun on both sides, the full flags and saturated levels all come up often during a long random run, where they would be rare at 64. A behavioural model built on queues tracks every output on every clock. Directed phases cover overrun, underrun, the trailing timeout, write-1-to-clear priority and flush on disable. A random phase then mixes simultaneous traffic, trigger changes and enable toggles.

// File: rtl/hq_pkg.sv
package hq_pkg;
  localparam int BYTE_W   = 8;
  localparam int NSRC     = 7;
  localparam int SRC_TXAE = 0;
  localparam int SRC_RXAF = 1;
  localparam int SRC_TXUF = 2;
  localparam int SRC_TXOF = 3;
  localparam int SRC_RXUF = 4;
  localparam int SRC_RXOF = 5;
  localparam int SRC_TRL  = 6;
  localparam int LVLF_W   = 7;

  typedef struct packed {
    logic             empty;
    logic             full;
    logic [LVLF_W-1:0] level;
  } qstat_t;
endpackage

// File: rtl/hq_fifo.sv
module hq_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty,
  output logic          ovf,
  output logic          udf
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          wr_ok, rd_ok;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign wr_ok = en && wr && !full;
  assign rd_ok = en && rd && !empty;
  assign ovf   = en && wr && full;
  assign udf   = en && rd && empty;

  initial begin
    AST_DEPTH_OK: assert (DEPTH == 16 || DEPTH == 64); // R12
  end

  // storage and read port kept free of reset so a block RAM can be used
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wdata;
    if (rd_ok) rdata <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) rp <= rp + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(DEPTH)); // R4
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (en && wr && full) |=> cnt <= $past(cnt)); // R4
  AST_EMPTY_DROP: assert property (@(posedge clk) disable iff (rst)
    (en && rd && empty) |=> cnt >= $past(cnt)); // R5
  AST_FLUSH: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt == '0); // R11
endmodule

// File: rtl/hq_trail.sv
module hq_trail #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic [CW-1:0] rx_cnt,
  input  logic [CW-1:0] rx_trig,
  input  logic          push_ok,
  input  logic          tick,
  input  logic [3:0]    limit,
  output logic          evt
);
  logic [3:0] idle;
  logic       window;

  assign window = rx_en && (rx_cnt != '0) && (rx_cnt < rx_trig);
  assign evt    = window && !push_ok && tick && (idle == limit);

  always_ff @(posedge clk) begin
    if (rst || !window || push_ok) idle <= '0;
    else if (tick && idle != limit) idle <= idle + 1'b1;
  end

  AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (window && !push_ok && $stable(limit)) |=> idle <= limit || $past(idle) > $past(limit)); // R8
endmodule

// File: rtl/hq_irq.sv
module hq_irq
  import hq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            lvl_txae,
  input  logic            lvl_rxaf,
  input  logic [4:0]      ev_set,
  input  logic [NSRC-1:0] clr,
  input  logic [NSRC-1:0] en,
  output logic [NSRC-1:0] stat,
  output logic            irq
);
  logic [4:0] sticky;

  assign stat = {sticky, lvl_rxaf, lvl_txae};

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky <= '0;
      irq    <= 1'b0;
    end else begin
      sticky <= (sticky & ~clr[NSRC-1:2]) | ev_set;
      irq    <= |(stat & en);
    end
  end

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
    (|ev_set) |=> ((stat[NSRC-1:2] & $past(ev_set)) == $past(ev_set))); // R9
  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    (|(clr[NSRC-1:2] & ~ev_set)) |=> ((stat[NSRC-1:2] & $past(clr[NSRC-1:2] & ~ev_set)) == '0)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !irq); // R10
endmodule

// File: rtl/i2c_byte_queues.sv
module i2c_byte_queues
  import hq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic [LVL_W-1:0]  tx_trig,
  input  logic [LVL_W-1:0]  rx_trig,
  input  logic [3:0]        trail_lim,
  input  logic              idle_tick,
  input  logic              tx_wr,
  input  logic [7:0]        tx_wdata,
  input  logic              rx_rd,
  output logic [7:0]        rx_rdata,
  input  logic              eng_tx_pop,
  output logic [7:0]        eng_tx_data,
  input  logic              eng_rx_push,
  input  logic [7:0]        eng_rx_data,
  input  logic [6:0]        irq_en,
  input  logic [6:0]        irq_clr,
  output logic [6:0]        irq_stat,
  output logic [31:0]       fifo_stat,
  output logic              irq
);
  logic [LVL_W-1:0] tx_cnt, rx_cnt;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_ovf, tx_udf, rx_ovf, rx_udf;
  logic trail_evt, rx_push_ok;
  qstat_t tx_q, rx_q;

  hq_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_txq (
    .clk(clk), .rst(rst), .en(tx_en),
    .wr(tx_wr), .wdata(tx_wdata), .rd(eng_tx_pop), .rdata(eng_tx_data),
    .cnt(tx_cnt), .full(tx_full), .empty(tx_empty), .ovf(tx_ovf), .udf(tx_udf));

  hq_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_rxq (
    .clk(clk), .rst(rst), .en(rx_en),
    .wr(eng_rx_push), .wdata(eng_rx_data), .rd(rx_rd), .rdata(rx_rdata),
    .cnt(rx_cnt), .full(rx_full), .empty(rx_empty), .ovf(rx_ovf), .udf(rx_udf));

  assign rx_push_ok = rx_en && eng_rx_push && !rx_full;

  hq_trail #(.CW(LVL_W)) u_trail (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_cnt(rx_cnt), .rx_trig(rx_trig),
    .push_ok(rx_push_ok), .tick(idle_tick), .limit(trail_lim), .evt(trail_evt));

  hq_irq u_irq (
    .clk(clk), .rst(rst),
    .lvl_txae(tx_en && (tx_cnt <= tx_trig)),
    .lvl_rxaf(rx_en && !rx_empty && (rx_cnt >= rx_trig)),
    .ev_set({trail_evt, rx_ovf, rx_udf, tx_ovf, tx_udf}),
    .clr(irq_clr), .en(irq_en), .stat(irq_stat), .irq(irq));

  assign tx_q      = '{empty: tx_empty, full: tx_full, level: LVLF_W'(tx_cnt)};
  assign rx_q      = '{empty: rx_empty, full: rx_full, level: LVLF_W'(rx_cnt)};
  assign fifo_stat = {7'b0, rx_q, 7'b0, tx_q};
endmodule

// File: tb/i2c_byte_queues_tb.sv
`timescale 1ns/1ps
module i2c_byte_queues_tb;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH) + 1;

  logic clk = 0, rst = 1;
  logic tx_en = 0, rx_en = 0, idle_tick = 0, tx_wr = 0, rx_rd = 0, eng_tx_pop = 0, eng_rx_push = 0;
  logic [LW-1:0] tx_trig = 0, rx_trig = 0;
  logic [3:0] trail_lim = 0;
  logic [7:0] tx_wdata = 0, eng_rx_data = 0, rx_rdata, eng_tx_data;
  logic [6:0] irq_en = 0, irq_clr = 0, irq_stat;
  logic [31:0] fifo_stat;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_byte_queues #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .tx_trig(tx_trig), .rx_trig(rx_trig),
    .trail_lim(trail_lim), .idle_tick(idle_tick), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
    .rx_rd(rx_rd), .rx_rdata(rx_rdata), .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .irq_en(irq_en), .irq_clr(irq_clr),
    .irq_stat(irq_stat), .fifo_stat(fifo_stat), .irq(irq));

  // behavioural model
  logic [7:0] txq[$], rxq[$];
  logic [4:0] m_sticky = 0;
  int m_idle = 0;
  logic m_irq = 0, txv = 0, rxv = 0;
  logic [7:0] m_txd = 0, m_rxd = 0;

  function automatic logic [1:0] lvl_bits();
    logic ae, af;
    ae = tx_en && (txq.size() <= int'(tx_trig));
    af = rx_en && rxq.size() != 0 && (rxq.size() >= int'(rx_trig));
    return {af, ae};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      txq.delete(); rxq.delete(); m_sticky = 0; m_idle = 0; m_irq = 0; txv = 0; rxv = 0;
    end else begin
      logic [4:0] set;
      bit tf, te, rf, re, win, pok;
      m_irq = |({m_sticky, lvl_bits()} & irq_en);
      tf = txq.size() == DEPTH; te = txq.size() == 0;
      rf = rxq.size() == DEPTH; re = rxq.size() == 0;
      win = rx_en && rxq.size() > 0 && rxq.size() < int'(rx_trig);
      pok = rx_en && eng_rx_push && !rf;
      set = 0; txv = 0; rxv = 0;
      if (tx_en) begin
        if (tx_wr && tf) set[1] = 1;
        if (eng_tx_pop && te) set[0] = 1;
        if (eng_tx_pop && !te) begin m_txd = txq.pop_front(); txv = 1; end
        if (tx_wr && !tf) txq.push_back(tx_wdata);
      end else txq.delete();
      if (rx_en) begin
        if (eng_rx_push && rf) set[3] = 1;
        if (rx_rd && re) set[2] = 1;
        if (rx_rd && !re) begin m_rxd = rxq.pop_front(); rxv = 1; end
        if (pok) rxq.push_back(eng_rx_data);
      end else rxq.delete();
      if (!win || pok) m_idle = 0;
      else if (idle_tick) begin
        if (m_idle == int'(trail_lim)) set[4] = 1;
        else m_idle++;
      end
      m_sticky = (m_sticky & ~irq_clr[6:2]) | set;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      logic [31:0] es;
      logic [6:0] est;
      es = 0;
      es[6:0] = 7'(txq.size()); es[7] = txq.size() == DEPTH; es[8] = txq.size() == 0;
      es[22:16] = 7'(rxq.size()); es[23] = rxq.size() == DEPTH; es[24] = rxq.size() == 0;
      est = {m_sticky, lvl_bits()};
      chk(fifo_stat == es, "R3,R11,R12 fifo_stat", fifo_stat, es);
      chk(irq_stat[0] == est[0], "R6 tx almost-empty", 32'(irq_stat[0]), 32'(est[0]));
      chk(irq_stat[1] == est[1], "R7 rx almost-full", 32'(irq_stat[1]), 32'(est[1]));
      chk(irq_stat[3:2] == est[3:2], "R4,R9 tx over/underrun", 32'(irq_stat[3:2]), 32'(est[3:2]));
      chk(irq_stat[5:4] == est[5:4], "R5,R9 rx over/underrun", 32'(irq_stat[5:4]), 32'(est[5:4]));
      chk(irq_stat[6] == est[6], "R8 trailing", 32'(irq_stat[6]), 32'(est[6]));
      chk(irq == m_irq, "R10 irq", 32'(irq), 32'(m_irq));
      if (txv) chk(eng_tx_data == m_txd, "R1 tx data", 32'(eng_tx_data), 32'(m_txd));
      if (rxv) chk(rx_rdata == m_rxd, "R2 rx data", 32'(rx_rdata), 32'(m_rxd));
    end
  end

  task automatic idle_all();
    tx_wr = 0; rx_rd = 0; eng_tx_pop = 0; eng_rx_push = 0; idle_tick = 0; irq_clr = 0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); idle_all(); end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    cyc(2);
    tx_en = 1; rx_en = 1; tx_trig = 4; rx_trig = 8; trail_lim = 2; irq_en = 7'h7f;
    cyc(2);
    // R4: fill TX past full, then drain past empty
    for (int i = 0; i < 20; i++) begin @(negedge clk); idle_all(); tx_wr = 1; tx_wdata = 8'(8'h30 + i); end
    cyc(2);
    for (int i = 0; i < 18; i++) begin @(negedge clk); idle_all(); eng_tx_pop = 1; end
    cyc(2);
    // R5: fill RX past full, drain past empty
    for (int i = 0; i < 18; i++) begin @(negedge clk); idle_all(); eng_rx_push = 1; eng_rx_data = 8'(8'hA0 + i); end
    cyc(2);
    for (int i = 0; i < 18; i++) begin @(negedge clk); idle_all(); rx_rd = 1; end
    cyc(2);
    // R9: clear stickies
    @(negedge clk); idle_all(); irq_clr = 7'h7f;
    cyc(3);
    // R8: trailing timeout with 3 bytes below trigger
    for (int i = 0; i < 3; i++) begin @(negedge clk); idle_all(); eng_rx_push = 1; eng_rx_data = 8'(8'h50 + i); end
    for (int i = 0; i < 5; i++) begin @(negedge clk); idle_all(); idle_tick = 1; @(negedge clk); idle_all(); end
    // R9: clear coinciding with a fresh event
    @(negedge clk); idle_all(); idle_tick = 1; irq_clr = 7'h40;
    cyc(2);
    @(negedge clk); idle_all(); irq_clr = 7'h7f;
    cyc(2);
    // R11: disable with data held, accesses ignored
    for (int i = 0; i < 3; i++) begin @(negedge clk); idle_all(); tx_wr = 1; tx_wdata = 8'(i); end
    @(negedge clk); idle_all(); tx_en = 0; rx_en = 0;
    @(negedge clk); idle_all(); tx_wr = 1; eng_tx_pop = 1; rx_rd = 1; eng_rx_push = 1;
    cyc(3);
    tx_en = 1; rx_en = 1;
    cyc(2);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); idle_all();
      tx_wr = $urandom_range(0, 2) != 0; tx_wdata = 8'($urandom);
      eng_tx_pop = $urandom_range(0, 2) == 0;
      eng_rx_push = $urandom_range(0, 2) != 0; eng_rx_data = 8'($urandom);
      rx_rd = $urandom_range(0, 2) == 0;
      idle_tick = $urandom_range(0, 3) == 0;
      irq_clr = ($urandom_range(0, 15) == 0) ? 7'($urandom) : 7'h0;
      if ($urandom_range(0, 63) == 0) begin
        tx_trig = LW'($urandom_range(0, DEPTH)); rx_trig = LW'($urandom_range(0, DEPTH));
        trail_lim = 4'($urandom); irq_en = 7'($urandom);
      end
      if ($urandom_range(0, 255) == 0) tx_en = ~tx_en;
      if ($urandom_range(0, 255) == 0) rx_en = ~rx_en;
      if (i % 800 < 200) begin eng_tx_pop = 0; rx_rd = 0; end
    end
    cyc(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule